// File: doc/BRIEF.md
# Scaled Index Address Generator

This unit forms the address of a load or store from a base value and an index register value. The index first passes through a shifter whose kind and amount come from an immediate field. The shifted index is then added to or subtracted from the base. A pre/post selector decides whether the memory access uses the adjusted value or the untouched base. In both modes the adjusted value is offered as the new base. The write-back enable is raised only when the instruction's condition held. For pre-indexed requests, the request must also ask for write-back. Post-indexed requests always write back when the condition holds.

Requests enter on a valid/ready stream and leave on a second valid/ready stream through one register stage. The input accepts a request on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result is frozen and new requests are refused. The plain register-offset form uses the same path with a left shift of zero.

Top module: `sidx_addr_gen`

## Requirements
- R1: Shift kind 0 (`sh_kind_i` = 2'b00) shifts the index left by `sh_amt_i` places, 0 to 31. An amount of 0 passes the index unchanged.
- R2: Shift kind 1 (2'b01) is a logical right shift by `sh_amt_i`. An amount of 0 stands for a shift by 32, which gives an index of zero.
- R3: Shift kind 2 (2'b10) is an arithmetic right shift by `sh_amt_i`. An amount of 0 stands for a shift by 32, which gives all ones when index bit 31 is set and zero otherwise.
- R4: Shift kind 3 (2'b11) with a nonzero amount rotates the index right by that amount. An amount of 0 gives `{carry_i, index_i[31:1]}`.
- R5: With `add_i` = 1 the adjusted value is base plus shifted index. With `add_i` = 0 it is base minus shifted index, modulo 2^32.
- R6: With `pre_i` = 1, `addr_o` is the adjusted value and `wb_en_o` equals `cond_ok_i AND wback_i`.
- R7: With `pre_i` = 0, `addr_o` is the unmodified base and `wb_en_o` equals `cond_ok_i`.
- R8: `wb_data_o` always carries the adjusted value. With `cond_ok_i` = 0, `wb_en_o` stays low while the address is still produced.
- R9: After reset `out_valid` is low. An accepted request appears on the outputs at the next rising edge. With no new acceptance, a drained output clears `out_valid` at the next edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `addr_o`, `wb_data_o` and `wb_en_o` hold their values.
- R11: `wb_en_o` is low whenever `out_valid` is low. Each delivered result therefore shows at most one write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| carry_i | input | 1 | Carry flag, used by rotate-with-extend |
| sh_amt_i | input | 5 | Immediate shift amount |
| sh_kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| add_i | input | 1 | 1 adds the index, 0 subtracts it |
| pre_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| wback_i | input | 1 | Write-back requested (pre-indexed only) |
| cond_ok_i | input | 1 | Condition passed for this request |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| addr_o | output | 32 | Memory access address |
| wb_data_o | output | 32 | New base value |
| wb_en_o | output | 1 | Write the new base |

## Verification
A corrupted output register shows up at the ports one cycle after the request is accepted. It can appear as a wrong address, a wrong new base or a write-back flag with the wrong polarity. A valid flag that fails to clear would repeat a write-back on the next cycle, and a lost hold under back-pressure would change the fields while the consumer is stalled. Both show in the cycle right after the fault. The special zero-amount encodings give distinctive values: zero, all ones, or the carry in bit 31. Decoding them as ordinary shifts therefore gives a visibly different index in the very first result.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/sidx_index_shifter.sv
module sidx_index_shifter
  import sidx_pkg::*;
#(
  parameter int W = XLEN,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic          carry_i,
  input  logic [SW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  idx_o
);
  // logarithmic right rotator, one stage per amount bit
  logic [W-1:0] rot_stage [0:SW];
  assign rot_stage[0] = val_i;

  for (genvar k = 0; k < SW; k++) begin : g_rot
    localparam int SH = 2 ** k;
    assign rot_stage[k+1] = amt_i[k]
      ? {rot_stage[k][SH-1:0], rot_stage[k][W-1:SH]}
      : rot_stage[k];
  end

  logic amt_zero;
  assign amt_zero = (amt_i == '0);

  always_comb begin
    unique case (kind_i)
      SHK_LSL: idx_o = val_i << amt_i;
      SHK_LSR: idx_o = amt_zero ? '0 : (val_i >> amt_i);
      SHK_ASR: idx_o = amt_zero ? {W{val_i[W-1]}}
                                : W'($signed(val_i) >>> amt_i);
      SHK_ROR: idx_o = amt_zero ? {carry_i, val_i[W-1:1]}
                                : rot_stage[SW];
      default: idx_o = '0;
    endcase
  end
endmodule

// File: rtl/sidx_offset_adder.sv
module sidx_offset_adder #(
  parameter int W = sidx_pkg::XLEN
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] idx_i,
  input  logic         add_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] operand;
  // subtraction as base + ~idx + 1
  assign operand = add_i ? idx_i : ~idx_i;
  assign sum_o   = base_i + operand + {{(W-1){1'b0}}, ~add_i};
endmodule

// File: rtl/sidx_result_stage.sv
module sidx_result_stage #(
  parameter int W = sidx_pkg::XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         drain_i,
  input  logic [W-1:0] addr_d,
  input  logic [W-1:0] wbv_d,
  input  logic         wben_d,
  output logic         valid_o,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] wbv_q,
  output logic         wben_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_q  <= '0;
      wbv_q   <= '0;
      wben_q  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_q  <= addr_d;
      wbv_q   <= wbv_d;
      wben_q  <= wben_d;
    end else if (drain_i) begin
      valid_o <= 1'b0;
      wben_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sidx_addr_gen.sv
module sidx_addr_gen
  import sidx_pkg::*;
#(
  parameter int W = XLEN,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  base_i,
  input  logic [W-1:0]  index_i,
  input  logic          carry_i,
  input  logic [SW-1:0] sh_amt_i,
  input  logic [1:0]    sh_kind_i,
  input  logic          add_i,
  input  logic          pre_i,
  input  logic          wback_i,
  input  logic          cond_ok_i,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  addr_o,
  output logic [W-1:0]  wb_data_o,
  output logic          wb_en_o
);
  logic [W-1:0] shifted_idx;
  logic [W-1:0] adjusted;
  logic [W-1:0] addr_next;
  logic         wben_next;
  logic         accept;

  sidx_index_shifter #(.W(W)) u_shift (
    .val_i  (index_i),
    .carry_i(carry_i),
    .amt_i  (sh_amt_i),
    .kind_i (shift_kind_e'(sh_kind_i)),
    .idx_o  (shifted_idx)
  );

  sidx_offset_adder #(.W(W)) u_add (
    .base_i(base_i),
    .idx_i (shifted_idx),
    .add_i (add_i),
    .sum_o (adjusted)
  );

  // post-indexed always updates the base; pre-indexed only on request
  assign addr_next = pre_i ? adjusted : base_i;
  assign wben_next = cond_ok_i & (~pre_i | wback_i);

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  sidx_result_stage #(.W(W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .drain_i(out_ready),
    .addr_d (addr_next),
    .wbv_d  (adjusted),
    .wben_d (wben_next),
    .valid_o(out_valid),
    .addr_q (addr_o),
    .wbv_q  (wb_data_o),
    .wben_q (wb_en_o)
  );
endmodule

// File: rtl/sidx_addr_gen_chk.sv
module sidx_addr_gen_chk #(
  parameter int W = sidx_pkg::XLEN
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] base_i,
  input logic         pre_i,
  input logic         cond_ok_i,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] addr_o,
  input logic [W-1:0] wb_data_o,
  input logic         wb_en_o
);
  logic acc;
  assign acc = in_valid & in_ready;

  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r9_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && (!out_valid || out_ready)) |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(addr_o)
      && $stable(wb_data_o) && $stable(wb_en_o)));

  a_r11_wb_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wb_en_o);

  a_r7_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pre_i) |=> (addr_o == $past(base_i)));

  a_r8_cond_block: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cond_ok_i) |=> !wb_en_o);
endmodule

bind sidx_addr_gen sidx_addr_gen_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .base_i   (base_i),
  .pre_i    (pre_i),
  .cond_ok_i(cond_ok_i),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .addr_o   (addr_o),
  .wb_data_o(wb_data_o),
  .wb_en_o  (wb_en_o)
);

// File: tb/sidx_addr_gen_test.sv
`timescale 1ns/1ps
module sidx_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] base_i = '0;
  logic [31:0] index_i = '0;
  logic        carry_i = 1'b0;
  logic [4:0]  sh_amt_i = '0;
  logic [1:0]  sh_kind_i = '0;
  logic        add_i = 1'b0;
  logic        pre_i = 1'b0;
  logic        wback_i = 1'b0;
  logic        cond_ok_i = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] addr_o;
  logic [31:0] wb_data_o;
  logic        wb_en_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sidx_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_i(base_i), .index_i(index_i), .carry_i(carry_i),
    .sh_amt_i(sh_amt_i), .sh_kind_i(sh_kind_i), .add_i(add_i),
    .pre_i(pre_i), .wback_i(wback_i), .cond_ok_i(cond_ok_i),
    .out_valid(out_valid), .out_ready(out_ready), .addr_o(addr_o),
    .wb_data_o(wb_data_o), .wb_en_o(wb_en_o)
  );

  function automatic logic [31:0] model_idx(logic [31:0] v, logic c,
                                            logic [4:0] amt, logic [1:0] kind);
    logic [31:0] r = v;
    int n = (amt == 0) ? 32 : int'(amt);
    case (kind)
      2'd0: for (int i = 0; i < int'(amt); i++) r = {r[30:0], 1'b0};
      2'd1: for (int i = 0; i < n; i++) r = {1'b0, r[31:1]};
      2'd2: for (int i = 0; i < n; i++) r = {r[31], r[31:1]};
      default:
        if (amt == 0) r = {c, v[31:1]};
        else for (int i = 0; i < int'(amt); i++) r = {r[0], r[31:1]};
    endcase
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] b, logic [31:0] x, logic c, logic [4:0] a,
                       logic [1:0] k, logic up, logic pr, logic wb, logic co);
    base_i = b; index_i = x; carry_i = c; sh_amt_i = a; sh_kind_i = k;
    add_i = up; pre_i = pr; wback_i = wb; cond_ok_i = co;
  endtask

  task automatic expect_out(string req);
    logic [31:0] idx = model_idx(index_i, carry_i, sh_amt_i, sh_kind_i);
    logic [31:0] adj = add_i ? base_i + idx : base_i - idx;
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, addr_o, pre_i ? adj : base_i);
    chk(req, wb_data_o, adj);
    chk(req, {31'd0, wb_en_o}, {31'd0, cond_ok_i & (~pre_i | wback_i)});
  endtask

  task automatic one(string req, logic [31:0] b, logic [31:0] x, logic c,
                     logic [4:0] a, logic [1:0] k, logic up, logic pr,
                     logic wb, logic co);
    @(negedge clk);
    drive(b, x, c, a, k, up, pr, wb, co);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_a;
    logic [31:0] hold_w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en_o}, 32'd0);
    chk("R10 reset ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    one("R1 lsl0",  32'h1000, 32'h0000_0123, 0, 5'd0,  2'd0, 1, 1, 0, 1);
    one("R1 lsl31", 32'h1000, 32'h0000_0003, 0, 5'd31, 2'd0, 1, 1, 0, 1);
    one("R2 lsr32", 32'h2000, 32'hFFFF_FFFF, 0, 5'd0,  2'd1, 1, 1, 1, 1);
    one("R2 lsr4",  32'h2000, 32'hF000_00F0, 0, 5'd4,  2'd1, 1, 1, 1, 1);
    one("R3 asr32n",32'h3000, 32'h8000_0000, 0, 5'd0,  2'd2, 1, 1, 1, 1);
    one("R3 asr32p",32'h3000, 32'h7FFF_FFFF, 0, 5'd0,  2'd2, 1, 1, 1, 1);
    one("R3 asr8",  32'h3000, 32'h8000_1200, 0, 5'd8,  2'd2, 1, 1, 1, 1);
    one("R4 rrx",   32'h4000, 32'h0000_0003, 1, 5'd0,  2'd3, 1, 1, 1, 1);
    one("R4 ror8",  32'h4000, 32'h1234_5678, 0, 5'd8,  2'd3, 1, 1, 1, 1);
    one("R5 sub",   32'h0000_0010, 32'h20, 0, 5'd0, 2'd0, 0, 1, 1, 1);
    one("R6 nowb",  32'h5000, 32'h44, 0, 5'd2, 2'd0, 1, 1, 0, 1);
    one("R7 post",  32'h6000, 32'h44, 0, 5'd2, 2'd0, 0, 0, 0, 1);
    one("R8 condf", 32'h7000, 32'h10, 0, 5'd1, 2'd0, 1, 0, 1, 0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] rb = $urandom;
      logic [31:0] rx = $urandom;
      logic [31:0] rc = $urandom;
      one("R5 random", rb, rx, rc[0], rc[5:1], rc[7:6], rc[8], rc[9],
          rc[10], rc[11]);
    end

    // back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(32'hA000, 32'h1, 0, 5'd3, 2'd0, 1, 1, 1, 1);
    in_valid = 1'b1;
    @(negedge clk);
    expect_out("R10 first");
    hold_a = addr_o;
    hold_w = wb_data_o;
    drive(32'hB000, 32'h2, 0, 5'd1, 2'd0, 0, 0, 0, 1);
    chk("R10 stall ready", {31'd0, in_ready}, 32'd0);
    repeat (2) begin
      @(negedge clk);
      chk("R10 hold addr", addr_o, hold_a);
      chk("R10 hold wb", wb_data_o, hold_w);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R10 second");
    @(negedge clk);
    chk("R9 drained", {31'd0, out_valid}, 32'd0);
    chk("R11 idle wb_en", {31'd0, wb_en_o}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule